// File: doc/BRIEF.md
# Multi-Channel Conversion Scheduler

This block is the digital controller in front of a pipelined converter with four result channels. Software writes one control word that holds a start bit for each channel, a flush bit, an enable bit and a two-bit field that sets how channels share DMA requests. The block keeps every requested channel pending and issues one conversion per converter tick into a model of the converter pipeline. The pipeline has a fixed depth, and the tick is the peripheral clock divided by a fixed ratio. The lowest-numbered pending channel goes first. When a conversion leaves the pipeline, the block raises a completion pulse and records the completion for the DMA request logic.

A flush throws away every conversion that is in flight. Channels that have not yet been issued stay pending. The divider starts counting again from zero, and the remaining channels then run to completion as usual. The grouping field can fold the completions of channels 0..g into a single request on line 0, so one DMA channel can serve a whole sweep.

Top module: `conv_sched`

## Requirements
- R1: Control word layout: bits [3:0] are the start bits for channels 0..3, bit 4 is flush, bit 5 is enable, and bits [7:6] are the group code. Reading back returns the pending mask in [3:0], 0 in bit 4, the enable bit and the group code. Every field is 0 after reset.
- R2: Pending channels are issued one per converter tick, lowest channel number first. Ticks fall every DIV peripheral cycles. After a write that turns the block on from disabled, the first tick falls on the DIV-th edge after the write edge.
- R3: A pending bit clears on the tick that issues its channel, not when the conversion completes.
- R4: A flush discards every in-flight conversion, and no completion pulse ever appears for one of them.
- R5: A flush restarts the divider. The first tick after it falls DIV edges after the flush write edge.
- R6: Channels still pending at a flush stay pending and later complete in ascending order.
- R7: The completion output for a channel is a one-cycle, one-hot pulse in the cycle after the LAT-th tick that follows its issue tick. For the k-th issued channel after an enabling write, this is sample cycle (LAT+1+k)*DIV after the write edge.
- R8: With group code 0, request line c follows channel c. With code g from 1 to 3, channels 0..g share request line 0, lines 1..g stay low, and the channels above g keep their own lines.
- R9: A shared request asserts only after every member of its group has completed since the last acknowledge. Acknowledge line c clears the completions that line c covers.
- R10: A start written for a channel that is already pending is absorbed and yields a single conversion.
- R11: A write with enable = 0 drops all pending and in-flight work. Start bits in such a write are ignored, and the block raises no tick while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 8 | Control word written on wrEn |
| regRd | output | 8 | Control word read-back |
| dmaAck | input | 4 | Per-line DMA acknowledge |
| doneFlag | output | 4 | One-cycle completion pulse per channel |
| dmaReq | output | 4 | DMA request lines after grouping |
| convTick | output | 1 | Converter clock enable |

## Verification
Sweeps are run with random channel masks and random group codes. Each starts from a disabled block, so the completion time of every channel is exactly predictable, and the per-cycle comparison separates wrong issue order, wrong latency and a lost or extra conversion. Directed cases cover the following:
- A flush placed after two issues: only the later channels may complete, and their timing must follow a restarted divider.
- A partial completion of a full group: the shared request must wait.
- A duplicate start before issue.
- Start writes while disabled.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  localparam int unsigned CHAN_IDX_W = 4;

  typedef struct packed {
    logic                  tick;
    logic                  flush;
    logic                  kill;
    logic                  issue;
    logic [CHAN_IDX_W-1:0] issueCh;
  } ctrlStrobe_t;
endpackage

// File: rtl/conv_sched_ctrl.sv
module conv_sched_ctrl
  import conv_sched_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DIV = 2,
  parameter int unsigned GW  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [NCH+GW+1:0]   wrData,
  output logic [NCH+GW+1:0]   regRd,
  output logic [GW-1:0]       groupSel,
  output ctrlStrobe_t         strb
);
  localparam int unsigned DCW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] pendQ, pendNxt;
  logic           enQ;
  logic [GW-1:0]  grpQ;
  logic [DCW-1:0] divCnt;

  logic [NCH-1:0] wrStart;
  logic           wrFlush, wrEnable, flushNow, killNow, tick, found;
  logic [CHW-1:0] issueSel;

  assign wrStart  = wrData[NCH-1:0];
  assign wrFlush  = wrData[NCH];
  assign wrEnable = wrData[NCH+1];
  assign flushNow = wrEn && wrFlush && wrEnable && enQ;
  assign killNow  = wrEn && !wrEnable;
  assign tick     = enQ && (divCnt == DCW'(DIV-1)) && !flushNow && !killNow;

  // lowest pending channel wins
  always_comb begin
    found    = 1'b0;
    issueSel = '0;
    for (int i = NCH-1; i >= 0; i--) begin
      if (pendQ[i]) begin
        found    = 1'b1;
        issueSel = CHW'(i);
      end
    end
  end

  always_comb begin
    pendNxt = pendQ;
    if (tick && found) pendNxt[issueSel] = 1'b0;
    if (wrEn) begin
      if (!wrEnable) pendNxt = '0;
      else           pendNxt = pendNxt | wrStart;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ  <= '0;
      enQ    <= 1'b0;
      grpQ   <= '0;
      divCnt <= '0;
    end else begin
      pendQ <= pendNxt;
      if (wrEn) begin
        enQ  <= wrEnable;
        grpQ <= wrData[NCH+GW+1 -: GW];
      end
      if (!enQ || flushNow || killNow || divCnt == DCW'(DIV-1)) divCnt <= '0;
      else                                                      divCnt <= divCnt + 1'b1;
    end
  end

  assign groupSel     = grpQ;
  assign regRd        = {grpQ, enQ, 1'b0, pendQ};
  assign strb.tick    = tick;
  assign strb.flush   = flushNow;
  assign strb.kill    = killNow;
  assign strb.issue   = tick && found;
  assign strb.issueCh = CHAN_IDX_W'(issueSel);

  // R2: nothing below the issued channel may still be waiting
  a_r2_lowest_first: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> ((pendQ & ((NCH'(1) << issueSel) - NCH'(1))) == '0));

  // R3: the issued channel is no longer pending afterwards
  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && !wrEn) |=> !pendQ[$past(issueSel)]);

  // R5: the divider restarts, so no tick right after a flush
  a_r5_flush_restart: assert property (@(posedge clk) disable iff (!rstN)
    (flushNow && DIV > 1) |=> !tick);

  // R11: disabling leaves nothing pending
  a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    killNow |=> (regRd[NCH-1:0] == '0 && !tick));
endmodule

// File: rtl/conv_sched_dp.sv
module conv_sched_dp
  import conv_sched_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned LAT = 4,
  parameter int unsigned GW  = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strb,
  input  logic [GW-1:0]   groupSel,
  input  logic [NCH-1:0]  dmaAck,
  output logic [NCH-1:0]  doneFlag,
  output logic [NCH-1:0]  dmaReq
);
  logic                  stVld [LAT];
  logic [CHAN_IDX_W-1:0] stCh  [LAT];
  logic [NCH-1:0]        doneQ, seenQ, grpMask, ackClr;
  logic                  grpAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LAT; i++) begin
        stVld[i] <= 1'b0;
        stCh[i]  <= '0;
      end
      doneQ <= '0;
    end else if (strb.flush || strb.kill) begin
      for (int i = 0; i < LAT; i++) stVld[i] <= 1'b0;
      doneQ <= '0;
    end else if (strb.tick) begin
      stVld[0] <= strb.issue;
      stCh[0]  <= strb.issueCh;
      for (int i = 1; i < LAT; i++) begin
        stVld[i] <= stVld[i-1];
        stCh[i]  <= stCh[i-1];
      end
      doneQ <= stVld[LAT-1] ? (NCH'(1) << stCh[LAT-1]) : '0;
    end else begin
      doneQ <= '0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign grpMask[c] = (groupSel != '0) && (c <= int'(groupSel));
    assign ackClr[c]  = grpMask[c] ? dmaAck[0] : dmaAck[c];
    if (c == 0) begin : g_lead
      assign dmaReq[c] = grpMask[0] ? grpAll : seenQ[0];
    end else begin : g_rest
      assign dmaReq[c] = grpMask[c] ? 1'b0 : seenQ[c];
    end
  end

  assign grpAll = ((seenQ & grpMask) == grpMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenQ <= '0;
    else       seenQ <= (seenQ & ~ackClr) | doneQ;
  end

  assign doneFlag = doneQ;

  // R7: at most one completion per cycle
  a_r7_done_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(doneFlag));

  // R4: flushed work never completes in the following cycle
  a_r4_flush_drops: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (doneFlag == '0));

  // R8: grouped lines other than line 0 stay quiet
  a_r8_group_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((dmaReq & grpMask & ~NCH'(1)) == '0));

  // R9: a full acknowledge with no new completion empties every line
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAck == '1 && doneQ == '0) |=> (dmaReq == '0));
endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import conv_sched_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DIV = 2,
  parameter int unsigned LAT = 4,
  parameter int unsigned GW  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [NCH+GW+1:0] wrData,
  output logic [NCH+GW+1:0] regRd,
  input  logic [NCH-1:0]    dmaAck,
  output logic [NCH-1:0]    doneFlag,
  output logic [NCH-1:0]    dmaReq,
  output logic              convTick
);
  ctrlStrobe_t   strb;
  logic [GW-1:0] groupSel;

  conv_sched_ctrl #(.NCH(NCH), .DIV(DIV), .GW(GW)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .regRd(regRd), .groupSel(groupSel), .strb(strb)
  );

  conv_sched_dp #(.NCH(NCH), .LAT(LAT), .GW(GW)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .groupSel(groupSel),
    .dmaAck(dmaAck), .doneFlag(doneFlag), .dmaReq(dmaReq)
  );

  assign convTick = strb.tick;
endmodule

// File: tb/test_conv_sched.sv
module test_conv_sched;
  localparam int CLK_P = 10;
  localparam int NCH = 4, DIV = 2, LAT = 4, GW = 2;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [3:0] dmaAck = '0;
  logic [7:0] regRd;
  logic [3:0] doneFlag, dmaReq;
  logic convTick;
  int nChecks = 0, nFails = 0;

  conv_sched #(.NCH(NCH), .DIV(DIV), .LAT(LAT), .GW(GW)) i_conv_sched (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .regRd(regRd),
    .dmaAck(dmaAck), .doneFlag(doneFlag), .dmaReq(dmaReq), .convTick(convTick)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic writeReg(logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic ackLines(logic [3:0] a);
    dmaAck = a;
    @(negedge clk);
    dmaAck = '0;
  endtask

  function automatic logic [3:0] expDone(logic [3:0] mask, int n);
    logic [3:0] r = '0;
    int k = 0;
    for (int c = 0; c < NCH; c++) begin
      if (mask[c]) begin
        if (n == (LAT + 1 + k) * DIV) r[c] = 1'b1;
        k++;
      end
    end
    return r;
  endfunction

  function automatic logic [3:0] expReq(logic [3:0] seen, logic [1:0] g);
    logic [3:0] m, r;
    if (g == 2'd0) return seen;
    m = 4'((5'd1 << (g + 1)) - 5'd1);
    r = seen & ~m;
    if ((seen & m) == m) r[0] = 1'b1;
    return r;
  endfunction

  // R2, R7: sweep from a disabled block, compare completion per cycle
  task automatic sweep(logic [3:0] mask, logic [1:0] g);
    writeReg(8'h00);
    writeReg({g, 1'b1, 1'b0, mask});
    for (int n = 0; n <= (LAT + NCH + 2) * DIV; n++) begin
      check("R7 sweep completion timing", 32'(doneFlag), 32'(expDone(mask, n)));
      @(negedge clk);
    end
    check("R8 request lines after sweep", 32'(dmaReq), 32'(expReq(mask, g)));
    ackLines(4'hF);
    check("R9 full acknowledge clears", 32'(dmaReq), 32'h0);
  endtask

  initial begin
    #(CLK_P * 150000);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int ones;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset read-back", 32'(regRd), 32'h0);
    check("R1 reset done", 32'(doneFlag), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: layout read-back with flush reading 0
    writeReg(8'b10_1_1_0000);
    check("R1 read-back fields", 32'(regRd), 32'hA0);

    // R11: start bits ignored while disabled
    writeReg(8'h00);
    writeReg(8'b00_0_0_1111);
    check("R11 disabled start ignored", 32'(regRd), 32'h0);
    ones = 0;
    for (int n = 0; n < 30; n++) begin
      if (doneFlag != 0 || convTick) ones++;
      @(negedge clk);
    end
    check("R11 no activity while disabled", 32'(ones), 32'h0);

    // R3: pending bits clear on issue
    writeReg(8'b00_1_0_0101);
    check("R3 pending after write", 32'(regRd[3:0]), 32'h5);
    @(negedge clk); @(negedge clk);
    check("R3 ch0 cleared on issue", 32'(regRd[3:0]), 32'h4);
    @(negedge clk); @(negedge clk);
    check("R3 ch2 cleared on issue", 32'(regRd[3:0]), 32'h0);
    repeat (30) @(negedge clk);
    ackLines(4'hF);

    // R4, R5, R6: flush after ch0/ch1 issued, ch2/ch3 still pending
    writeReg(8'h00);
    writeReg(8'b00_1_0_1111);
    repeat (4) @(negedge clk);
    writeReg(8'b00_1_1_0000);
    check("R6 pending kept over flush", 32'(regRd[3:0]), 32'hC);
    for (int n = 0; n <= (LAT + 6) * DIV; n++) begin
      check("R4 R5 R6 post-flush completion", 32'(doneFlag), 32'(expDone(4'b1100, n)));
      @(negedge clk);
    end
    check("R4 flushed channels absent", 32'(dmaReq), 32'hC);
    ackLines(4'hF);

    // R10: duplicate start absorbed
    writeReg(8'h00);
    writeReg(8'b00_1_0_0010);
    writeReg(8'b00_1_0_0010);
    ones = 0;
    for (int n = 0; n < 30; n++) begin
      if (doneFlag[1]) ones++;
      @(negedge clk);
    end
    check("R10 single conversion", 32'(ones), 32'h1);
    ackLines(4'hF);

    // R9: shared request waits for the whole group
    writeReg(8'h00);
    writeReg(8'b11_1_0_0111);
    repeat (30) @(negedge clk);
    check("R9 partial group no request", 32'(dmaReq), 32'h0);
    writeReg(8'b11_1_0_1000);
    repeat (30) @(negedge clk);
    check("R9 full group request", 32'(dmaReq), 32'h1);
    ackLines(4'h1);
    check("R9 shared acknowledge", 32'(dmaReq), 32'h0);

    // R2, R7, R8: random sweeps
    for (int t = 0; t < 40; t++) begin
      sweep(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)));
    end
    sweep(4'hF, 2'd0);
    sweep(4'h8, 2'd2);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule